// File: doc/BRIEF.md
# Reverse Channel Seizure Arbitration Monitor

This block decides whether a mobile unit has won access to a shared reverse control channel. While a burst is going out, the base station reports the channel state as busy/idle bits on the forward control channel. The block smooths those bits with a majority filter and times the response against two fixed windows counted in bit periods. The outcome is either a successful seizure or a collision.

A collision sets a sticky failure flag and raises a one-cycle failure event. When aborting is enabled, it also forces the transmitter enable to its inactive level and raises a one-cycle abort request for the transmit encoder. Only an explicit reset-arbitration command releases the flag and the forced-off transmitter. The filtered busy status and the transmitter enable each have a programmable output polarity.

Top module: `rca_arbiter`

## Requirements
- R1: The filtered busy status is the majority of the three most recently strobed busy/idle bits, with a bit value of 1 meaning busy. After reset the history holds idle (0).
- R2: Each change of the filtered busy status raises `busyChange` for exactly one clock cycle.
- R3: With `busyPolInv` = 1, `busyStatus` is the inverse of the filtered status. With `busyPolInv` = 0 it equals the filtered status.
- R4: A `txStart` pulse starts monitoring with the bit-period counter at zero. The counter advances by one on each `bitTick` while monitoring.
- R5: A filtered busy status seen while the counter is below 56 is a collision.
- R6: A filtered busy status seen while the counter is between 56 and 103 inclusive is a successful seizure. Monitoring ends and no collision follows.
- R7: If the filtered status is still idle when the counter reaches 104, that is a collision.
- R8: A collision sets `arbFailFlag` and raises `arbFailEvt` for exactly one cycle.
- R9: If `abortEn` = 1 at a collision, `txEnable` goes to its inactive level and `txAbortReq` pulses for one cycle. If `abortEn` = 0, neither of these happens.
- R10: `arbFailFlag`, and a forced-off transmitter enable, stay in place until an `arbClear` pulse clears both.
- R11: A `txStart` pulse while `arbFailFlag` is set does not start monitoring and cannot raise a new failure event.
- R12: With `txEnPolInv` = 0, an active transmitter enable reads 1. With `txEnPolInv` = 1 it reads 0. After reset the enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe per bit period |
| biBit | input | 1 | Busy/idle bit, 1 = busy |
| biValid | input | 1 | Strobe qualifying `biBit` |
| txStart | input | 1 | Reverse-channel burst start pulse |
| arbClear | input | 1 | Reset-arbitration command pulse |
| abortEn | input | 1 | Collision forces transmitter off and requests abort |
| busyPolInv | input | 1 | Invert `busyStatus` |
| txEnPolInv | input | 1 | Invert `txEnable` |
| busyStatus | output | 1 | Filtered busy status, polarity applied |
| busyChange | output | 1 | One-cycle pulse on filtered status change |
| arbFailEvt | output | 1 | One-cycle collision event |
| arbFailFlag | output | 1 | Sticky collision flag |
| txAbortReq | output | 1 | One-cycle request to abort transmit data |
| txEnable | output | 1 | Transmitter enable, polarity applied |

## Verification
The bench builds the block with its default parameters: early window 56, late limit 104 and a vote depth of 3. It spaces `bitTick` two clocks apart, so both window edges (counts 55/56 and 103/104) are reached within a few hundred cycles. This lets the bench test each edge on both sides. Vote depth 3 makes the alternating patterns that flip the majority on consecutive strobes short enough to drive directly.

// File: rtl/rca_pkg.sv
package rca_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic setFail;
    logic clearFail;
  } rcaCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic busy;
    logic inEarly;
    logic lateHit;
    logic failed;
  } rcaStat_t;

  typedef enum logic [0:0] {ST_IDLE, ST_WATCH} rcaState_t;
endpackage

// File: rtl/rca_datapath.sv
module rca_datapath
  import rca_pkg::*;
#(
  parameter int EARLY_WIN  = 56,
  parameter int LATE_WIN   = 104,
  parameter int VOTE_DEPTH = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     biBit,
  input  logic     biValid,
  input  logic     abortEn,
  input  rcaCtrl_t ctrl,
  output rcaStat_t stat,
  output logic     busyRaw,
  output logic     busyChange,
  output logic     failEvt,
  output logic     failFlag,
  output logic     abortReq,
  output logic     killTx
);
  localparam int CNT_W     = $clog2(LATE_WIN + 1);
  localparam int VOTE_NEED = (VOTE_DEPTH + 1) / 2;
  localparam logic [CNT_W-1:0] EARLY_CNT = EARLY_WIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] LATE_CNT  = LATE_WIN[CNT_W-1:0];

  logic [VOTE_DEPTH-1:0] hist;
  logic                  prevBusy;
  logic [CNT_W-1:0]      cnt;

  // busy/idle history, newest bit in position 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hist <= '0;
    else if (biValid) hist <= {hist[VOTE_DEPTH-2:0], biBit};
  end

  assign busyRaw = ($countones(hist) >= VOTE_NEED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevBusy <= 1'b0;
    else       prevBusy <= busyRaw;
  end

  assign busyChange = busyRaw ^ prevBusy;

  // bit-period counter, saturates at the late limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               cnt <= '0;
    else if (ctrl.cntClear)                  cnt <= '0;
    else if (ctrl.cntRun && cnt != LATE_CNT) cnt <= cnt + 1'b1;
  end

  // sticky failure state; a set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      killTx   <= 1'b0;
      failEvt  <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      failEvt  <= ctrl.setFail;
      abortReq <= ctrl.setFail & abortEn;
      if (ctrl.setFail) begin
        failFlag <= 1'b1;
        if (abortEn) killTx <= 1'b1;
      end else if (ctrl.clearFail) begin
        failFlag <= 1'b0;
        killTx   <= 1'b0;
      end
    end
  end

  assign stat.busy    = busyRaw;
  assign stat.inEarly = (cnt < EARLY_CNT);
  assign stat.lateHit = (cnt >= LATE_CNT);
  assign stat.failed  = failFlag;
endmodule

// File: rtl/rca_control.sv
module rca_control
  import rca_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitTick,
  input  logic     txStart,
  input  logic     arbClear,
  input  rcaStat_t stat,
  output rcaCtrl_t ctrl
);
  rcaState_t state, nxt;
  logic      startOk;

  assign startOk = txStart && !stat.failed;

  always_comb begin
    ctrl           = '0;
    ctrl.clearFail = arbClear;
    nxt            = state;
    unique case (state)
      ST_IDLE: begin
        if (startOk) begin
          ctrl.cntClear = 1'b1;
          nxt           = ST_WATCH;
        end
      end
      ST_WATCH: begin
        if (startOk) begin
          ctrl.cntClear = 1'b1;          // new burst restarts the window
        end else if (stat.busy) begin
          ctrl.setFail = stat.inEarly;   // early busy = someone else seized
          nxt          = ST_IDLE;
        end else if (stat.lateHit) begin
          ctrl.setFail = 1'b1;           // no seizure response in time
          nxt          = ST_IDLE;
        end else begin
          ctrl.cntRun = bitTick;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end
endmodule

// File: rtl/rca_arbiter.sv
module rca_arbiter
  import rca_pkg::*;
#(
  parameter int EARLY_WIN  = 56,
  parameter int LATE_WIN   = 104,
  parameter int VOTE_DEPTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic biBit,
  input  logic biValid,
  input  logic txStart,
  input  logic arbClear,
  input  logic abortEn,
  input  logic busyPolInv,
  input  logic txEnPolInv,
  output logic busyStatus,
  output logic busyChange,
  output logic arbFailEvt,
  output logic arbFailFlag,
  output logic txAbortReq,
  output logic txEnable
);
  rcaCtrl_t ctrl;
  rcaStat_t stat;
  logic     busyRaw;
  logic     killTx;

  rca_control u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txStart(txStart),
    .arbClear(arbClear), .stat(stat), .ctrl(ctrl)
  );

  rca_datapath #(
    .EARLY_WIN(EARLY_WIN), .LATE_WIN(LATE_WIN), .VOTE_DEPTH(VOTE_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .biBit(biBit), .biValid(biValid),
    .abortEn(abortEn), .ctrl(ctrl), .stat(stat), .busyRaw(busyRaw),
    .busyChange(busyChange), .failEvt(arbFailEvt), .failFlag(arbFailFlag),
    .abortReq(txAbortReq), .killTx(killTx)
  );

  assign busyStatus = busyRaw ^ busyPolInv;
  assign txEnable   = ~killTx ^ txEnPolInv;
endmodule

// File: rtl/rca_arbiter_chk.sv
module rca_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic arbClear,
  input logic busyPolInv,
  input logic txEnPolInv,
  input logic busyStatus,
  input logic busyChange,
  input logic arbFailEvt,
  input logic arbFailFlag,
  input logic txAbortReq,
  input logic txEnable
);
  p_evt_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    arbFailEvt |=> !arbFailEvt);

  p_evt_sets_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    arbFailEvt |-> arbFailFlag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (arbFailFlag && !arbClear) |=> arbFailFlag);

  p_abort_with_evt_r9: assert property (@(posedge clk) disable iff (!rstN)
    txAbortReq |-> arbFailEvt);

  p_txen_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    !arbFailFlag |-> (txEnable != txEnPolInv));

  p_change_real_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busyChange && $stable(busyPolInv)) |-> (busyStatus != $past(busyStatus)));
endmodule

bind rca_arbiter rca_arbiter_chk u_chk (
  .clk(clk), .rstN(rstN), .arbClear(arbClear), .busyPolInv(busyPolInv),
  .txEnPolInv(txEnPolInv), .busyStatus(busyStatus), .busyChange(busyChange),
  .arbFailEvt(arbFailEvt), .arbFailFlag(arbFailFlag),
  .txAbortReq(txAbortReq), .txEnable(txEnable)
);

// File: tb/tb_rca_arbiter.sv
`timescale 1ns/1ps
module tb_rca_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 0, biBit = 0, biValid = 0, txStart = 0, arbClear = 0;
  logic abortEn = 0, busyPolInv = 0, txEnPolInv = 0;
  logic busyStatus, busyChange, arbFailEvt, arbFailFlag, txAbortReq, txEnable;

  int testsRun = 0;
  int testsFailed = 0;
  int evtCyc = 0, abortCyc = 0, chgCyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rca_arbiter dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .biBit(biBit), .biValid(biValid),
    .txStart(txStart), .arbClear(arbClear), .abortEn(abortEn),
    .busyPolInv(busyPolInv), .txEnPolInv(txEnPolInv), .busyStatus(busyStatus),
    .busyChange(busyChange), .arbFailEvt(arbFailEvt), .arbFailFlag(arbFailFlag),
    .txAbortReq(txAbortReq), .txEnable(txEnable)
  );

  // pulse-width counters sampled away from the active edge
  always @(negedge clk) begin
    if (arbFailEvt) evtCyc++;
    if (txAbortReq) abortCyc++;
    if (busyChange) chgCyc++;
  end

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bitTick = 1;
      @(negedge clk) bitTick = 0;
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) begin biBit = b; biValid = 1; end
    @(negedge clk) biValid = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) txStart = 1;
    @(negedge clk) txStart = 0;
  endtask

  task automatic pulseClear();
    @(negedge clk) arbClear = 1;
    @(negedge clk) arbClear = 0;
  endtask

  task automatic flushIdle();
    for (int i = 0; i < 3; i++) sendBit(0);
  endtask

  task automatic t_reset();
    check("R1 reset status idle", busyStatus, 0);
    check("R2 reset no change", busyChange, 0);
    check("R8 reset flag clear", arbFailFlag, 0);
    check("R12 reset enable active", txEnable, 1);
    check("R9 reset no abort", txAbortReq, 0);
  endtask

  task automatic t_majority();
    int c0;
    c0 = chgCyc;
    sendBit(1); idle(1);
    check("R1 one busy of three", busyStatus, 0);
    sendBit(1); idle(1);
    check("R1 two busy of three", busyStatus, 1);
    check("R2 single-cycle change", chgCyc - c0, 1);
    sendBit(0); idle(1);
    check("R1 110 majority busy", busyStatus, 1);
    sendBit(0); idle(1);
    check("R1 100 majority idle", busyStatus, 0);
    sendBit(1); sendBit(0); sendBit(1); idle(1);
    check("R1 101 majority busy", busyStatus, 1);
    check("R2 change count", chgCyc - c0, 3);
    busyPolInv = 1; idle(2);
    check("R3 inverted busy", busyStatus, 0);
    busyPolInv = 0; idle(1);
    flushIdle(); idle(1);
    check("R3 normal idle", busyStatus, 0);
  endtask

  task automatic t_early_fail();
    int e0, a0, c0;
    abortEn = 1;
    e0 = evtCyc; a0 = abortCyc;
    pulseStart();
    ticks(55);
    sendBit(1); sendBit(1); idle(3);
    check("R5 busy at 55 collides", arbFailFlag, 1);
    check("R8 one event cycle", evtCyc - e0, 1);
    check("R9 abort pulse", abortCyc - a0, 1);
    check("R9 enable forced off", txEnable, 0);
    flushIdle(); idle(20);
    check("R10 flag held", arbFailFlag, 1);
    check("R10 enable still off", txEnable, 0);
    txEnPolInv = 1; idle(1);
    check("R12 inverted inactive", txEnable, 1);
    txEnPolInv = 0;
    c0 = evtCyc;
    pulseStart();
    ticks(110);
    check("R11 start ignored while failed", evtCyc - c0, 0);
    pulseClear(); idle(1);
    check("R10 clear drops flag", arbFailFlag, 0);
    check("R10 clear restores enable", txEnable, 1);
    txEnPolInv = 1; idle(1);
    check("R12 inverted active", txEnable, 0);
    txEnPolInv = 0;
  endtask

  task automatic t_seize_ok();
    int e0;
    e0 = evtCyc;
    pulseStart();
    ticks(56);
    sendBit(1); sendBit(1); idle(3);
    check("R6 busy at 56 succeeds", arbFailFlag, 0);
    flushIdle();
    ticks(60);
    check("R6 no later collision", evtCyc - e0, 0);
    check("R4 enable active after success", txEnable, 1);
  endtask

  task automatic t_late_fail();
    int e0, a0;
    abortEn = 0;
    e0 = evtCyc; a0 = abortCyc;
    pulseStart();
    ticks(103); idle(3);
    check("R7 idle at 103 no collision", arbFailFlag, 0);
    ticks(1); idle(2);
    check("R7 idle at 104 collides", arbFailFlag, 1);
    check("R8 event once", evtCyc - e0, 1);
    check("R9 no abort when disabled", abortCyc - a0, 0);
    check("R9 enable stays active", txEnable, 1);
    pulseClear(); idle(1);
    check("R10 cleared", arbFailFlag, 0);
  endtask

  task automatic t_restart();
    int e0;
    e0 = evtCyc;
    pulseStart();
    ticks(100);
    pulseStart();          // restart: counter back to zero
    ticks(60);
    check("R4 restart resets counter", evtCyc - e0, 0);
    sendBit(1); sendBit(1); idle(3);
    check("R4 busy at 60 after restart ok", arbFailFlag, 0);
    flushIdle();
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    t_reset();
    t_majority();
    t_early_fail();
    t_seize_ok();
    t_late_fail();
    t_restart();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule